// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates 32-bit virtual addresses into physical addresses by walking a two-level page table that sits in ordinary memory. A translation request arrives over a valid/ready handshake. The walker splits the address into three fields: a top-level index, a second-level index and an in-page offset. It then issues two dependent word reads on a simple request/response memory port. It returns either the physical address or a page-fault code, together with a one-cycle result strobe.

The top-level table is located by a single table-base input, which is the only per-process state. A table-length input bounds the top-level index. Both inputs are captured when a request is accepted. Each table entry is one 32-bit word. The frame number sits in the upper 20 bits and a valid flag sits in bit 0. Bits 11:1 are ignored. Only one walk is in flight at a time, and no results are cached.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: Once a request is accepted, `req_ready` stays 0 until the result strobe has been given. Any request presented during a walk is ignored and does not change the result of the walk.
- R3: If the top-level index (`va[31:22]`) is greater than or equal to `tbl_len`, the result is fault code 1 with `rsp_pa` = 0, and no memory read is issued.
- R4: The first read address is `{tbl_base, 12'h000} + va[31:22]*4`.
- R5: If bit 0 of the first entry is 0, the result is fault code 2 with `rsp_pa` = 0, after exactly one read.
- R6: The second read address is `{entry1[31:12], 12'h000} + va[21:12]*4`.
- R7: If bit 0 of the second entry is 0, the result is fault code 3 with `rsp_pa` = 0, after exactly two reads.
- R8: On success, the result is fault code 0 with `rsp_pa = {entry2[31:12], va[11:0]}`, after exactly two reads. Entry bits 11:1 have no effect.
- R9: `rsp_valid` is a one-cycle pulse, and `req_ready` returns to 1 in the next cycle.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` stays stable.
- R11: `tbl_base` and `tbl_len` are sampled at acceptance. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 20 | Frame number of the top-level table |
| tbl_len | input | 11 | Number of valid top-level entries |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_pa | output | 32 | Physical address, or 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 length, 2 top-level invalid, 3 second-level invalid |

## Verification
A wrong walk state shows up at the memory port before any result appears. A stray or missing read, a wrong entry address, or an address that changes while stalled is visible in the same cycle, and the bench compares every read against the expected sequence. A wrong latched table frame or index shows up in the second read address. A wrong fault decision shows up at the single result strobe, as a wrong code, a non-zero address on a fault, or a wrong read count. A state machine that does not return to idle shows up one cycle after the strobe, because `req_ready` stays low.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_LEN   = 2'd1,
      FLT_OUTER = 2'd2,
      FLT_INNER = 2'd3
   } pgw_fault_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_READ_L1 = 3'd1,
      ST_WAIT_L1 = 3'd2,
      ST_READ_L2 = 3'd3,
      ST_WAIT_L2 = 3'd4,
      ST_DONE    = 3'd5
   } pgw_state_e;

endpackage

// File: rtl/pgw_entry_addr.sv
// Forms the byte address of a table entry from a table frame and an index.
module pgw_entry_addr #(
   parameter int FRAME_W = 20,
   parameter int OFF_W   = 12,
   parameter int IDX_W   = 10,
   parameter int SHIFT   = 2
) (
   input  logic [FRAME_W-1:0]       frame,
   input  logic [IDX_W-1:0]         idx,
   output logic [FRAME_W+OFF_W-1:0] addr
);
   localparam int AW = FRAME_W + OFF_W;

   generate
      if (IDX_W + SHIFT <= OFF_W) begin : g_concat
         // the scaled index fits inside the page: no carry into the frame
         logic [OFF_W-1:0] low;
         assign low  = OFF_W'(idx) << SHIFT;
         assign addr = {frame, low};
      end else begin : g_add
         assign addr = {frame, {OFF_W{1'b0}}} + (AW'(idx) << SHIFT);
      end
   endgenerate
endmodule

// File: rtl/pgw_bound_chk.sv
// Compares the top-level index against the table length.
module pgw_bound_chk #(
   parameter int IDX_W  = 10,
   parameter bit ENABLE = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W:0]   len,
   output logic             in_range
);
   generate
      if (ENABLE) begin : g_cmp
         assign in_range = ({1'b0, idx} < len);
      end else begin : g_none
         logic unused_bound;
         assign unused_bound = ^{idx, len};
         assign in_range     = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pgw_fsm.sv
// Walk sequencer: captures the request, steps through both reads, forms the result.
module pgw_fsm
   import pgw_pkg::*;
#(
   parameter int OUT_W = 10,
   parameter int IN_W  = 10,
   parameter int OFF_W = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [OUT_W+IN_W+OFF_W-1:0] req_va,
   input  logic [OUT_W+IN_W-1:0]     base_frame,
   input  logic                      len_ok,
   output logic                      mem_req_valid,
   input  logic                      mem_req_ready,
   input  logic                      mem_rsp_valid,
   input  logic [OUT_W+IN_W+OFF_W-1:0] mem_rsp_data,
   output logic [OUT_W+IN_W-1:0]     tbl_frame,
   output logic [OUT_W-1:0]          tbl_idx_hi,
   output logic [IN_W-1:0]           tbl_idx_lo,
   output logic                      use_hi,
   output logic                      rsp_valid,
   output logic [OUT_W+IN_W+OFF_W-1:0] rsp_pa,
   output pgw_fault_e                rsp_fault
);
   localparam int VA_W = OUT_W + IN_W + OFF_W;
   localparam int FR_W = OUT_W + IN_W;

   pgw_state_e        st_q, st_d;
   logic [VA_W-1:0]   va_q;
   logic [FR_W-1:0]   frame_q;
   logic [VA_W-1:0]   pa_q;
   pgw_fault_e        fault_q;

   logic              entry_ok;
   logic [FR_W-1:0]   entry_frame;
   logic              unused_pte;

   assign entry_ok    = mem_rsp_data[0];
   assign entry_frame = mem_rsp_data[VA_W-1:OFF_W];
   assign unused_pte  = ^mem_rsp_data[OFF_W-1:1];

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (req_valid) st_d = len_ok ? ST_READ_L1 : ST_DONE;
         ST_READ_L1: if (mem_req_ready) st_d = ST_WAIT_L1;
         ST_WAIT_L1: if (mem_rsp_valid) st_d = entry_ok ? ST_READ_L2 : ST_DONE;
         ST_READ_L2: if (mem_req_ready) st_d = ST_WAIT_L2;
         ST_WAIT_L2: if (mem_rsp_valid) st_d = ST_DONE;
         ST_DONE:    st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         va_q    <= '0;
         frame_q <= '0;
         pa_q    <= '0;
         fault_q <= FLT_NONE;
      end else begin
         st_q <= st_d;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  frame_q <= base_frame;
                  pa_q    <= '0;
                  fault_q <= len_ok ? FLT_NONE : FLT_LEN;
               end
            end
            ST_WAIT_L1: begin
               if (mem_rsp_valid) begin
                  if (entry_ok) frame_q <= entry_frame;
                  else          fault_q <= FLT_OUTER;
               end
            end
            ST_WAIT_L2: begin
               if (mem_rsp_valid) begin
                  if (entry_ok) pa_q    <= {entry_frame, va_q[OFF_W-1:0]};
                  else          fault_q <= FLT_INNER;
               end
            end
            default: ;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_READ_L1) || (st_q == ST_READ_L2);
   assign use_hi        = (st_q == ST_READ_L1);
   assign tbl_frame     = frame_q;
   assign tbl_idx_hi    = va_q[VA_W-1 -: OUT_W];
   assign tbl_idx_lo    = va_q[OFF_W +: IN_W];
   assign rsp_valid     = (st_q == ST_DONE);
   assign rsp_pa        = pa_q;
   assign rsp_fault     = fault_q;
endmodule

// File: rtl/pgw_walker.sv
// Top level: two-level table walk with a bounded top-level index.
module pgw_walker #(
   parameter int VA_W      = 32,
   parameter int OUT_W     = 10,
   parameter int IN_W      = 10,
   parameter int OFF_W     = 12,
   parameter int ENTRY_B   = 4,
   parameter bit LEN_CHECK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [VA_W-1:0]      req_va,
   input  logic [VA_W-OFF_W-1:0] tbl_base,
   input  logic [OUT_W:0]       tbl_len,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [VA_W-1:0]      mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [VA_W-1:0]      mem_rsp_data,
   output logic                 rsp_valid,
   output logic [VA_W-1:0]      rsp_pa,
   output logic [1:0]           rsp_fault
);
   localparam int FR_W  = VA_W - OFF_W;
   localparam int SHIFT = $clog2(ENTRY_B);
   localparam int MAX_W = (OUT_W > IN_W) ? OUT_W : IN_W;

   if (OUT_W + IN_W + OFF_W != VA_W) begin : g_bad_split
      $error("pgw_walker: index and offset widths must sum to VA_W");
   end
   if (ENTRY_B * 8 != VA_W) begin : g_bad_entry
      $error("pgw_walker: an entry must be one address-wide word");
   end
   if ((1 << SHIFT) != ENTRY_B) begin : g_bad_pow2
      $error("pgw_walker: entry size must be a power of two");
   end

   logic                 len_ok;
   logic [FR_W-1:0]      tbl_frame;
   logic [OUT_W-1:0]     idx_hi;
   logic [IN_W-1:0]      idx_lo;
   logic                 use_hi;
   logic [MAX_W-1:0]     idx_sel;
   pgw_pkg::pgw_fault_e  fault;

   pgw_bound_chk #(.IDX_W(OUT_W), .ENABLE(LEN_CHECK)) u_bound (
      .idx      (req_va[VA_W-1 -: OUT_W]),
      .len      (tbl_len),
      .in_range (len_ok)
   );

   pgw_fsm #(.OUT_W(OUT_W), .IN_W(IN_W), .OFF_W(OFF_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_va        (req_va),
      .base_frame    (tbl_base),
      .len_ok        (len_ok),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .tbl_frame     (tbl_frame),
      .tbl_idx_hi    (idx_hi),
      .tbl_idx_lo    (idx_lo),
      .use_hi        (use_hi),
      .rsp_valid     (rsp_valid),
      .rsp_pa        (rsp_pa),
      .rsp_fault     (fault)
   );

   assign idx_sel   = use_hi ? MAX_W'(idx_hi) : MAX_W'(idx_lo);
   assign rsp_fault = fault;

   pgw_entry_addr #(.FRAME_W(FR_W), .OFF_W(OFF_W), .IDX_W(MAX_W), .SHIFT(SHIFT)) u_eaddr (
      .frame (tbl_frame),
      .idx   (idx_sel),
      .addr  (mem_req_addr)
   );
endmodule

// File: rtl/pgw_walker_chk.sv
// Protocol checker, attached to every pgw_walker instance.
module pgw_walker_chk #(
   parameter int VA_W  = 32,
   parameter int OFF_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_va,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [VA_W-1:0] mem_req_addr,
   input logic            rsp_valid,
   input logic [VA_W-1:0] rsp_pa,
   input logic [1:0]      rsp_fault
);
   logic [VA_W-1:0] va_seen;
   logic [1:0]      reads;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_seen <= '0;
         reads   <= '0;
      end else if (req_valid && req_ready) begin
         va_seen <= req_va;
         reads   <= '0;
      end else if (mem_req_valid && mem_req_ready && reads != 2'd3) begin
         reads <= reads + 2'd1;
      end
   end

   p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);
   p_len_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd1) |-> (reads == 2'd0 && rsp_pa == '0));
   p_outer_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd2) |-> (reads == 2'd1 && rsp_pa == '0));
   p_inner_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd3) |-> (reads == 2'd2 && rsp_pa == '0));
   p_ok_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd0) |-> (reads == 2'd2 &&
       rsp_pa[OFF_W-1:0] == va_seen[OFF_W-1:0]));
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind pgw_walker pgw_walker_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_va        (req_va),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .rsp_valid     (rsp_valid),
   .rsp_pa        (rsp_pa),
   .rsp_fault     (rsp_fault)
);

// File: tb/pgw_walker_tb_top.sv
`timescale 1ns/1ps
module pgw_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic [19:0] tbl_base = 20'h00001;
   logic [10:0] tbl_len = 11'd18;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic [1:0]  rsp_fault;

   pgw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .tbl_base(tbl_base), .tbl_len(tbl_len),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
      .rsp_fault(rsp_fault)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_addr [4];
   int          rd_cnt = 0;
   bit          pend = 1'b0;
   int          pend_dly = 0;
   logic [31:0] pend_addr = '0;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected outcome from the requirement text alone.
   task automatic model(input logic [31:0] va, input logic [19:0] base,
                        input logic [10:0] len, output logic [1:0] f,
                        output logic [31:0] pa, output int nr,
                        output logic [31:0] a1, output logic [31:0] a2);
      logic [31:0] e1, e2;
      f = 2'd0; pa = 32'h0; nr = 0; a1 = 32'h0; a2 = 32'h0;
      if ({1'b0, va[31:22]} >= len) begin
         f = 2'd1;
         return;
      end
      a1 = {base, 12'h000} + {20'h0, va[31:22], 2'b00};
      e1 = rd(a1);
      nr = 1;
      if (!e1[0]) begin
         f = 2'd2;
         return;
      end
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = rd(a2);
      nr = 2;
      if (!e2[0]) begin
         f = 2'd3;
         return;
      end
      pa = {e2[31:12], va[11:0]};
   endtask

   // Memory port: records accepted reads, answers after 0..2 extra cycles.
   always @(posedge clk) begin
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
         rd_cnt    = rd_cnt + 1;
         pend      = 1'b1;
         pend_addr = mem_req_addr;
         pend_dly  = $urandom % 3;
      end
   end

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = $urandom;
      if (pend) begin
         if (pend_dly == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(pend_addr);
            pend          = 1'b0;
         end else begin
            pend_dly = pend_dly - 1;
         end
      end
      mem_req_ready = $urandom % 2;
   end

   task automatic xlate(input logic [31:0] va, input bit busy_req, input bit cfg_swap);
      logic [1:0]  ef;
      logic [31:0] epa, ea1, ea2;
      int          enr;
      int          t;
      logic [19:0] sv_base;
      logic [10:0] sv_len;
      @(negedge clk);
      t = 0;
      while (!req_ready && t < 100) begin @(negedge clk); t++; end
      sv_base = tbl_base;
      sv_len  = tbl_len;
      model(va, tbl_base, tbl_len, ef, epa, enr, ea1, ea2);
      rd_cnt    = 0;
      req_valid = 1'b1;
      req_va    = va;
      @(negedge clk);
      chk(req_ready == 1'b0, "R2 busy after accept", {31'h0, req_ready}, 32'h0);
      if (busy_req) req_va = va ^ 32'hFFC0_0000;
      else          req_valid = 1'b0;
      if (cfg_swap) begin
         tbl_base = 20'h00040;
         tbl_len  = 11'd0;
      end
      t = 0;
      while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
      req_valid = 1'b0;
      if (!rsp_valid) chk(1'b0, "watchdog walk timeout", 32'h0, 32'h1);
      case (ef)
         2'd1:    chk(rsp_fault == ef, "R3 length fault code", {30'h0, rsp_fault}, {30'h0, ef});
         2'd2:    chk(rsp_fault == ef, "R5 outer invalid code", {30'h0, rsp_fault}, {30'h0, ef});
         2'd3:    chk(rsp_fault == ef, "R7 inner invalid code", {30'h0, rsp_fault}, {30'h0, ef});
         default: chk(rsp_fault == ef, "R8 success code", {30'h0, rsp_fault}, {30'h0, ef});
      endcase
      chk(rsp_pa == epa, busy_req ? "R2 ignored request, pa" :
                         (cfg_swap ? "R11 sampled config, pa" : "R8 physical address"),
          rsp_pa, epa);
      chk(rd_cnt == enr, "R3 R5 R7 R8 read count", rd_cnt, enr);
      if (enr >= 1 && rd_cnt >= 1) chk(rd_addr[0] == ea1, "R4 first read address", rd_addr[0], ea1);
      if (enr >= 2 && rd_cnt >= 2) chk(rd_addr[1] == ea2, "R6 second read address", rd_addr[1], ea2);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 pulse then ready",
          {30'h0, rsp_valid, req_ready}, 32'h1);
      tbl_base = sv_base;
      tbl_len  = sv_len;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // table A (base frame 1): outer entries point to frames 0x100+o
      for (int o = 0; o < 16; o++) begin
         logic [19:0] fr;
         fr = 20'h100 + 20'(o);
         mem[{20'h00001, 12'h0} + 32'(o * 4)] = {fr, 11'($urandom), ($urandom % 4) != 0};
         for (int i = 0; i < 16; i++)
            mem[{fr, 12'h0} + 32'(i * 4)] = {20'($urandom), 11'($urandom), ($urandom % 4) != 0};
      end
      // table B (base frame 0x40): all valid, distinct frames
      for (int o = 0; o < 16; o++) begin
         logic [19:0] fr;
         fr = 20'h200 + 20'(o);
         mem[{20'h00040, 12'h0} + 32'(o * 4)] = {fr, 12'h001};
         for (int i = 0; i < 16; i++)
            mem[{fr, 12'h0} + 32'(i * 4)] = {20'hAB000 + 20'(o * 16 + i), 12'h001};
      end
      // directed entries
      mem[{20'h00001, 12'h0}]      = {20'h100, 11'h7FF, 1'b1};
      mem[{20'h100, 12'h0} + 12]   = {20'hFEDCB, 11'h555, 1'b1};
      mem[{20'h100, 12'h0} + 16]   = 32'hFFFF_F000;
      mem[{20'h00001, 12'h0} + 4]  = {20'h101, 11'h7FF, 1'b0};

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready in reset", {31'h0, req_ready}, 32'h1);
      chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 outputs quiet in reset",
          {30'h0, rsp_valid, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0,
          "R1 idle after reset", {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

      // directed corner cases
      xlate({10'd0, 10'd3, 12'hFFF}, 1'b0, 1'b0);   // R8 max offset, junk bits ignored
      xlate({10'd0, 10'd3, 12'h000}, 1'b0, 1'b0);   // R8 zero offset
      xlate({10'd1, 10'd2, 12'h123}, 1'b0, 1'b0);   // R5 outer invalid
      xlate({10'd0, 10'd4, 12'h456}, 1'b0, 1'b0);   // R7 inner invalid
      xlate({10'd17, 10'd0, 12'h001}, 1'b0, 1'b0);  // R3 last index inside length
      xlate({10'd18, 10'd0, 12'h001}, 1'b0, 1'b0);  // R3 index equal to length
      xlate({10'h3FF, 10'h3FF, 12'hABC}, 1'b0, 1'b0); // R3 top index
      xlate({10'd0, 10'd3, 12'h777}, 1'b1, 1'b0);   // R2 request during walk
      xlate({10'd0, 10'd3, 12'h321}, 1'b0, 1'b1);   // R11 config change mid-walk
      tbl_len = 11'd0;
      xlate({10'd0, 10'd3, 12'h000}, 1'b0, 1'b0);   // R3 zero length
      tbl_len = 11'd1024;
      xlate({10'd0, 10'd3, 12'h0F0}, 1'b0, 1'b0);   // R3 full length
      tbl_base = 20'h00040;
      xlate({10'd5, 10'd7, 12'h9A5}, 1'b0, 1'b0);   // R4 R6 other base
      tbl_base = 20'h00001;
      tbl_len  = 11'd18;

      // constrained random walks
      for (int k = 0; k < 300; k++) begin
         logic [31:0] va;
         va = {10'($urandom % 20), 10'($urandom % 18), 12'($urandom)};
         xlate(va, ($urandom % 5) == 0, ($urandom % 5) == 0);
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule